// File: doc/BRIEF.md
# Bytewide Calendar Clock Memory

This block is a byte-addressable synchronous memory. The eight highest addresses do not hold plain storage. They form a window onto a calendar clock that keeps seconds, minutes, hours, weekday, day of month, month and two-digit year, all in BCD. The clock advances from a tick input. A parameter sets how many tick pulses make one second, and a one-pulse-per-second source uses the default of one. Every lower address is ordinary read/write storage. Reads return data one cycle after the request.

The host never touches the live counters directly. It sees a seven-byte host copy:

- Normally the host copy follows the live counters on every cycle.
- A freeze flag holds the host copy still, so that all fields read together come from one instant.
- A staging flag turns the host copy into a write target. Clearing that flag loads every field into the live counters at once.

The live counters keep running through all of this. A power-good input shuts the host interface: while it is low, writes are dropped and reads return zero.

The buffer is run by a four-state machine:

- **TRACK**: the host copy follows the live counters. A control write with bit 7 set goes to STAGE. A control write with only bit 6 set goes to FREEZE.
- **FREEZE**: the host copy is held. A control write with bit 7 set goes to STAGE. A control write with both flag bits clear goes to TRACK.
- **STAGE**: field writes land in the host copy. A control write with bit 7 clear goes to COMMIT.
- **COMMIT**: lasts one cycle. The host copy loads into the live counters and the tick divider is cleared. The next state is FREEZE if the last written bit 6 was set, otherwise TRACK.

Top module: `cal_bytemem`

## Requirements
- R1: Addresses below the clock window store the byte written and return it on a read. Read data appears on `rdata` one cycle after the request, and is 0x00 in any cycle after no read was requested.
- R2: The clock window is the top eight addresses. Offsets within it, in address order, are: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. After reset the clock reads 00:00:00, weekday 01, day 01, month 01, year 00.
- R3: Every TICK_DIV tick pulses the clock advances one second, with seconds and minutes wrapping 59 to 00 and hours 23 to 00 in BCD. 23:59:59 becomes 00:00:00 and carries into the day.
- R4: The weekday counts 01 to 07 and wraps to 01 on each day carry, independently of the day of month.
- R5: After the last day of a month the day of month returns to 01 and the month advances. Months 04, 06, 09 and 11 end on 30. Month 02 ends on 29 when the BCD year is divisible by four (including 00) and on 28 otherwise. All other months end on 31.
- R6: The month wraps 12 to 01 and carries into the year, and the year wraps 99 to 00.
- R7: While control bit 6 is set (and bit 7 clear), reads of clock fields return the values captured when the flag was set, even as the clock advances. After the flag clears, reads show the live time again.
- R8: While control bit 7 is set, writes to clock fields are staged. Clearing bit 7 loads all staged fields into the live clock in one cycle and restarts the tick divider. Clock field writes while bit 7 is clear have no effect.
- R9: While `pwr_ok` is low, no write changes any location or control state, and a read returns 0x00.
- R10: A read of the control offset returns bit 7 = staging active, bit 6 = last written freeze flag, bits 5..0 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_ok | input | 1 | Supply in tolerance; low blocks host access |
| sec_tick | input | 1 | Tick pulse, one clock wide |
| ce | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the read |

## Verification
The bench builds the block with ADDR_W = 8 and TICK_DIV = 2. The small depth places the clock window at 0xF8 to 0xFF, so a few writes reach both sides of the storage boundary. A divider of two makes the divider restart on commit visible: one stray tick before a commit must not count toward the next second. The calendar corners are each reached by staging a time one second before the rollover and giving two ticks.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int NFLD   = 7;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DOW  = 3;
    localparam int F_DATE = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    localparam int CTRL_WBIT = 1;   // index into the two-bit flag pair taken from data bit 7
    localparam int CTRL_RBIT = 0;   // from data bit 6

    typedef logic [NFLD-1:0][7:0] caltime_t;

    typedef enum logic [1:0] {
        S_TRACK,
        S_FREEZE,
        S_STAGE,
        S_COMMIT
    } bufst_t;

    localparam caltime_t TIME_RST = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by four: even tens need units 0/4/8, odd tens need 2/6
    function automatic logic leap_bcd(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_time_core.sv
module cal_time_core
    import cal_pkg::*;
#(
    parameter int TICK_DIV = 1
)
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     load,
    input  caltime_t load_val,
    output caltime_t live
);

    localparam int            PW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pcnt;
    logic          sec_step;
    logic          c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0]    last_day;
    caltime_t      nxt;

    assign sec_step = tick && (pcnt == P_LAST);
    assign last_day = month_last(live[F_MON], live[F_YEAR]);

    // carry chain, each field steps only when every field below wraps
    always_comb begin
        nxt    = live;
        c_min  = (live[F_SEC] == 8'h59);
        c_hour = c_min  && (live[F_MIN]  == 8'h59);
        c_day  = c_hour && (live[F_HOUR] == 8'h23);
        c_mon  = c_day  && (live[F_DATE] >= last_day);
        c_year = c_mon  && (live[F_MON]  == 8'h12);

        nxt[F_SEC] = c_min ? 8'h00 : bcd_inc(live[F_SEC]);
        if (c_min)  nxt[F_MIN]  = (live[F_MIN]  == 8'h59) ? 8'h00 : bcd_inc(live[F_MIN]);
        if (c_hour) nxt[F_HOUR] = (live[F_HOUR] == 8'h23) ? 8'h00 : bcd_inc(live[F_HOUR]);
        if (c_day) begin
            nxt[F_DOW]  = (live[F_DOW] == 8'h07) ? 8'h01 : live[F_DOW] + 8'h01;
            nxt[F_DATE] = c_mon ? 8'h01 : bcd_inc(live[F_DATE]);
        end
        if (c_mon)  nxt[F_MON]  = c_year ? 8'h01 : bcd_inc(live[F_MON]);
        if (c_year) nxt[F_YEAR] = (live[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(live[F_YEAR]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
            live <= TIME_RST;
        end else if (load) begin
            pcnt <= '0;
            live <= load_val;
        end else if (tick) begin
            pcnt <= sec_step ? '0 : pcnt + 1'b1;
            if (sec_step) live <= nxt;
        end
    end

endmodule

// File: rtl/cal_buf_ctl.sv
module cal_buf_ctl
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [1:0] ctrl_flags,
    input  logic       fld_wr,
    input  logic [2:0] fld_sel,
    input  logic [7:0] fld_wdata,
    input  caltime_t   live,
    output caltime_t   snap,
    output logic       load,
    output logic       wflag,
    output logic       rflag
);

    bufst_t state, state_nxt;
    logic   rf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_TRACK;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_TRACK, S_FREEZE: begin
                if (ctrl_wr) begin
                    if (ctrl_flags[CTRL_WBIT])      state_nxt = S_STAGE;
                    else if (ctrl_flags[CTRL_RBIT]) state_nxt = S_FREEZE;
                    else                            state_nxt = S_TRACK;
                end
            end
            S_STAGE:  if (ctrl_wr && !ctrl_flags[CTRL_WBIT]) state_nxt = S_COMMIT;
            S_COMMIT: state_nxt = rf_q ? S_FREEZE : S_TRACK;
            default:  state_nxt = S_TRACK;
        endcase
    end

    always_comb begin
        load  = (state == S_COMMIT);
        wflag = (state == S_STAGE);
        rflag = rf_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rf_q <= 1'b0;
        else if (ctrl_wr) rf_q <= ctrl_flags[CTRL_RBIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap <= TIME_RST;
        end else begin
            unique case (state)
                S_TRACK: snap <= live;
                S_STAGE: if (fld_wr) snap[fld_sel] <= fld_wdata;
                default: snap <= snap;
            endcase
        end
    end

endmodule

// File: rtl/cal_bytemem.sv
module cal_bytemem
    import cal_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int TICK_DIV = 1
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              sec_tick,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic       acc, in_clk, ctrl_wr, fld_wr;
    logic [2:0] off, fld_sel;
    logic [7:0] rd_val;
    logic       load, wflag, rflag;
    caltime_t   live, snap;
    logic [7:0] mem [DEPTH];

    assign acc     = ce && pwr_ok;
    assign in_clk  = &addr[ADDR_W-1:3];
    assign off     = addr[2:0];
    assign fld_sel = off - 3'd1;
    assign ctrl_wr = acc && we && in_clk && (off == 3'd0);
    assign fld_wr  = acc && we && in_clk && (off != 3'd0);

    always_ff @(posedge clk) begin
        if (acc && we && !in_clk) mem[addr] <= wdata;
    end

    cal_time_core #(.TICK_DIV(TICK_DIV)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (load),
        .load_val (snap),
        .live     (live)
    );

    cal_buf_ctl u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_flags (wdata[7:6]),
        .fld_wr     (fld_wr),
        .fld_sel    (fld_sel),
        .fld_wdata  (wdata),
        .live       (live),
        .snap       (snap),
        .load       (load),
        .wflag      (wflag),
        .rflag      (rflag)
    );

    always_comb begin
        if (!in_clk)           rd_val = mem[addr];
        else if (off == 3'd0)  rd_val = {wflag, rflag, 6'b0};
        else                   rd_val = snap[fld_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= 8'h00;
        else        rdata <= (acc && !we) ? rd_val : 8'h00;
    end

endmodule

// File: rtl/cal_bytemem_chk.sv
module cal_bytemem_chk
    import cal_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_ok,
    input logic [7:0] rdata,
    input caltime_t   live,
    input caltime_t   snap,
    input logic       load,
    input logic       wflag,
    input logic       rflag
);

    // R9
    pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (rdata == 8'h00));

    // R3
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live[F_SEC] <= 8'h59) && (live[F_SEC][3:0] <= 4'd9));

    // R3
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live[F_HOUR] <= 8'h23);

    // R4
    dow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live[F_DOW] >= 8'h01) && (live[F_DOW] <= 8'h07));

    // R5
    date_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live[F_DATE] <= month_last(live[F_MON], live[F_YEAR]));

    // R7
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rflag && !wflag && !load) |=> $stable(snap));

    // R8
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (live == $past(snap)));

endmodule

bind cal_bytemem cal_bytemem_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pwr_ok (pwr_ok),
    .rdata  (rdata),
    .live   (live),
    .snap   (snap),
    .load   (load),
    .wflag  (wflag),
    .rflag  (rflag)
);

// File: tb/test_cal_bytemem.sv
`timescale 1ns/1ps
module test_cal_bytemem;

    localparam int AW = 8;
    localparam int TD = 2;
    localparam logic [AW-1:0] A_CTRL = 8'hF8;
    localparam logic [AW-1:0] A_SEC  = 8'hF9;
    localparam logic [AW-1:0] A_MIN  = 8'hFA;
    localparam logic [AW-1:0] A_HR   = 8'hFB;
    localparam logic [AW-1:0] A_DOW  = 8'hFC;
    localparam logic [AW-1:0] A_DATE = 8'hFD;
    localparam logic [AW-1:0] A_MON  = 8'hFE;
    localparam logic [AW-1:0] A_YR   = 8'hFF;

    logic          clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1, sec_tick = 1'b0;
    logic          ce = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;

    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    logic rd_issued = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] m_exp;
    string      m_tag;

    always #2 clk = ~clk;

    cal_bytemem #(.ADDR_W(AW), .TICK_DIV(TD)) i_cal_bytemem (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .sec_tick(sec_tick),
        .ce(ce), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always @(posedge clk) rd_issued <= ce && !we;

    // monitor: pops one expected byte per completed read
    always @(negedge clk) begin
        if (rd_issued) begin
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expectation, got %h expected none", rdata);
            end else begin
                m_exp = exp_q.pop_front();
                m_tag = tag_q.pop_front();
                checks++;
                if (rdata !== m_exp) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", m_tag, rdata, m_exp);
                end
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); ce = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk); ce = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        @(negedge clk); ce = 1'b1; we = 1'b0; addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk); ce = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sec_tick = 1'b1;
            @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(A_CTRL, 8'h80);
        wr(A_SEC, s); wr(A_MIN, m); wr(A_HR, h); wr(A_DOW, dw);
        wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, y);
        wr(A_CTRL, 8'h00);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 R10: reset contents of the clock window
        rd(A_CTRL, 8'h00, "R10 control after reset");
        rd(A_SEC,  8'h00, "R2 seconds after reset");
        rd(A_HR,   8'h00, "R2 hours after reset");
        rd(A_DOW,  8'h01, "R2 weekday after reset");
        rd(A_DATE, 8'h01, "R2 day after reset");
        rd(A_MON,  8'h01, "R2 month after reset");
        rd(A_YR,   8'h00, "R2 year after reset");

        // R1: plain storage below the window
        wr(8'h00, 8'hA5); wr(8'h7F, 8'h3C); wr(8'hF7, 8'h5A);
        rd(8'h00, 8'hA5, "R1 lowest byte");
        rd(8'h7F, 8'h3C, "R1 middle byte");
        rd(8'hF7, 8'h5A, "R1 byte below window");

        // R8: field write outside staging has no effect
        wr(A_SEC, 8'h33);
        rd(A_SEC, 8'h00, "R8 unstaged write ignored");

        // R3 R8: stray tick, then commit must restart the divider
        ticks(1);
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        ticks(1);
        wr(A_CTRL, 8'h40);
        rd(A_CTRL, 8'h40, "R10 freeze flag reads back");
        rd(A_SEC,  8'h59, "R8 divider restarted on commit");
        wr(A_CTRL, 8'h00);
        ticks(1);
        wr(A_CTRL, 8'h40);
        rd(A_SEC,  8'h00, "R3 seconds wrap");
        rd(A_MIN,  8'h00, "R3 minutes wrap");
        rd(A_HR,   8'h00, "R3 23:59:59 to midnight");
        rd(A_DOW,  8'h01, "R4 weekday 07 to 01");
        rd(A_DATE, 8'h01, "R5 31 Dec to 01");
        rd(A_MON,  8'h01, "R6 month 12 to 01");
        rd(A_YR,   8'h00, "R6 year 99 to 00");

        // R7: frozen copy holds while the clock runs on
        ticks(2);
        rd(A_SEC, 8'h00, "R7 frozen seconds hold");
        wr(A_CTRL, 8'h00);
        rd(A_SEC, 8'h01, "R7 copy resumes after release");
        rd(A_CTRL, 8'h00, "R10 flags cleared");

        // R3: BCD digit carry in the hours
        set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h06, 8'h23);
        ticks(2);
        rd(A_HR,  8'h10, "R3 hour 09 to 10");
        rd(A_MIN, 8'h00, "R3 minute wrap into hour");

        // R5: month lengths
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        ticks(2);
        rd(A_DATE, 8'h29, "R5 leap year 28 Feb to 29");
        rd(A_MON,  8'h02, "R5 leap year stays Feb");
        rd(A_DOW,  8'h04, "R4 weekday steps with day");

        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        ticks(2);
        rd(A_DATE, 8'h01, "R5 29 Feb to 01");
        rd(A_MON,  8'h03, "R5 leap Feb to Mar");

        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
        ticks(2);
        rd(A_DATE, 8'h01, "R5 non-leap 28 Feb to 01");
        rd(A_MON,  8'h03, "R5 non-leap Feb to Mar");

        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
        ticks(2);
        rd(A_DATE, 8'h29, "R5 year 00 is leap");

        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h23);
        ticks(2);
        rd(A_DATE, 8'h01, "R5 30 Apr to 01");
        rd(A_MON,  8'h05, "R5 Apr to May");

        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h01, 8'h23);
        ticks(2);
        rd(A_DATE, 8'h31, "R5 31-day month reaches 31");

        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h11, 8'h23);
        ticks(2);
        rd(A_MON, 8'h12, "R6 Nov to Dec");
        rd(A_YR,  8'h23, "R6 year held mid-year");

        // R9: power-good low blocks everything
        @(negedge clk); pwr_ok = 1'b0;
        rd(8'h00, 8'h00, "R9 read blocked");
        wr(8'h00, 8'hFF);
        wr(A_CTRL, 8'h40);
        @(negedge clk); pwr_ok = 1'b1;
        rd(8'h00,  8'hA5, "R9 write blocked");
        rd(A_CTRL, 8'h00, "R9 control write blocked");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule